// File: doc/BRIEF.md
# I2C Master Clock Generator with Bus Synchronization

This block produces the clock of an I2C master as an open-drain pull-low enable. It counts a programmable number of prescaler ticks for the released (high) part of each period and another count for the driven-low part. It does not count freely. Each phase counter starts from the level the block actually sees on the shared clock line. A slave that stretches the clock therefore lengthens the high phase, and a faster master that pulls the line low ends the high phase early.

The raw line input passes through a two-flop synchronizer and then a two-sample agreement filter, so a level is taken as seen only once two consecutive synchronized samples match. The high and low counts are captured only while the block is disabled. While disabled, the block releases the line and holds its counters cleared. The enclosing controller supplies the tick, the enable and the counts. START/STOP sequencing and data shifting belong elsewhere.

Top module: `i2c_scl_sync`

## Requirements
- R1: After reset, and on the cycle after `enable` is sampled low, `scl_pull_low` is 0 and the phase counter is cleared.
- R2: `cfg_high` and `cfg_low` are captured only while `enable` is 0. Changes made while enabled have no effect on the generated period.
- R3: With `tick` high every cycle and nobody else on the bus, `scl_pull_low` stays asserted for `cfg_low`+5 clock cycles. This is `cfg_low`+1 ticks after the low level is seen, plus a four-cycle detection latency.
- R4: With `tick` high every cycle, `scl_pull_low` reasserts exactly `cfg_high`+6 cycles after the line input returns high.
- R5: While the line is held low by another device after release, `scl_pull_low` stays 0 and the high count does not start until the line is seen high.
- R6: If the line is seen low during the high count, the block asserts `scl_pull_low` on the next cycle, five cycles after the line input falls. It then holds it for `cfg_low`+1 ticks.
- R7: The phase counter advances only on cycles with `tick` high. With `tick` held low, the block never pulls the line low.
- R8: A low pulse of one clock cycle on `scl_in` is filtered out and does not alter the high-phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; when low, the counts are loaded and the line is released |
| cfg_high | input | 8 | High-phase count minus one, in ticks |
| cfg_low | input | 8 | Low-phase count minus one, in ticks |
| tick | input | 1 | Prescaler pulse that advances the phase counter |
| scl_in | input | 1 | Raw clock line level |
| scl_pull_low | output | 1 | Open-drain pull-low enable for the clock line |

## Verification
The hardest situation to reach is a competing master pulling the line low in the middle of this block's high count. The detection latency must be accounted for exactly before the early switch to the low phase can be timed. The bench combines the block's own pull with an external low into the line level. It waits a fixed number of cycles into a long high phase, asserts the external low, and times both the delay to the pull and its length. Stretching and one-cycle glitches are injected the same way at known offsets after a release. The high and low counts are swept exhaustively over a small range.

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_low,
  input  logic          tick,
  input  logic          scl_in,
  output logic          scl_pull_low
);

  typedef enum logic [1:0] {WAIT_HI, CNT_HI, CNT_LO} phase_t;

  logic          s1, s2, s3, lvl;
  logic [CW-1:0] hi_q, lo_q, cnt;
  phase_t        st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1; lvl <= 1'b1;
    end else begin
      s1 <= scl_in;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3) lvl <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0;
    end else if (!enable) begin
      hi_q <= cfg_high; lo_q <= cfg_low;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= WAIT_HI; cnt <= '0;
    end else if (!enable) begin
      st <= WAIT_HI; cnt <= '0;
    end else begin
      unique case (st)
        WAIT_HI: if (lvl) begin st <= CNT_HI; cnt <= '0; end
        CNT_HI:
          if (!lvl) begin
            st <= CNT_LO; cnt <= '0;
          end else if (tick) begin
            if (cnt == hi_q) begin st <= CNT_LO; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        CNT_LO:
          if (lvl) cnt <= '0;
          else if (tick) begin
            if (cnt == lo_q) begin st <= WAIT_HI; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        default: begin st <= WAIT_HI; cnt <= '0; end
      endcase
    end

  assign scl_pull_low = (st == CNT_LO);

  a_r1_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && cnt == '0));

  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(hi_q) && $stable(lo_q)));

  a_r5_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == WAIT_HI && !lvl) |=> !scl_pull_low);

  a_r6_early_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == CNT_HI && !lvl) |=> scl_pull_low);

  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && cnt != '0) |-> $past(tick));

  a_r3_lo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CNT_LO) |-> (cnt <= lo_q));

  a_r4_hi_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CNT_HI) |-> (cnt <= hi_q));

endmodule

// File: tb/i2c_scl_sync_test.sv
`timescale 1ns/1ps
module i2c_scl_sync_test;
  logic clk = 0, rst_n = 0, enable = 0, tick = 1;
  logic [7:0] cfg_high = 0, cfg_low = 0;
  logic ext_low = 0, glitch = 0;
  logic scl_pull_low, scl_in;
  int checks = 0, errors = 0;

  assign scl_in = !scl_pull_low && !ext_low && !glitch;

  i2c_scl_sync uut (.clk(clk), .rst_n(rst_n), .enable(enable), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .tick(tick), .scl_in(scl_in), .scl_pull_low(scl_pull_low));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int h, input int l);
    @(negedge clk); enable = 0; cfg_high = 8'(h); cfg_low = 8'(l);
    repeat (6) @(negedge clk);
    enable = 1;
  endtask

  task automatic period(output int lo_n, output int hi_n);
    while (!scl_pull_low) @(negedge clk);
    lo_n = 0;
    while (scl_pull_low) begin lo_n++; @(negedge clk); end
    hi_n = 0;
    while (!scl_pull_low) begin hi_n++; @(negedge clk); end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo_n, hi_n, n;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(scl_pull_low), 0);
    rst_n = 1;

    for (int h = 0; h < 8; h++)
      for (int l = 0; l < 8; l++) begin
        setup(h, l);
        period(lo_n, hi_n);
        period(lo_n, hi_n);
        check("R3 low length", lo_n, l + 5);
        check("R4 high length", hi_n, h + 6);
      end

    setup(3, 2);
    @(negedge clk); cfg_high = 9; cfg_low = 9;
    period(lo_n, hi_n);
    period(lo_n, hi_n);
    check("R2 low ignores write", lo_n, 7);
    check("R2 high ignores write", hi_n, 9);

    while (!scl_pull_low) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check("R1 disable releases", int'(scl_pull_low), 0);

    setup(4, 3);
    while (!scl_pull_low) @(negedge clk);
    ext_low = 1;
    while (scl_pull_low) @(negedge clk);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (scl_pull_low) n++;
      @(negedge clk);
    end
    check("R5 no pull while stretched", n, 0);
    ext_low = 0;
    n = 0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
    check("R5 high after stretch", n, 10);

    setup(20, 3);
    while (!scl_pull_low) @(negedge clk);
    while (scl_pull_low) @(negedge clk);
    repeat (8) @(negedge clk);
    ext_low = 1;
    n = 0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
    check("R6 early pull delay", n, 5);
    ext_low = 0;
    n = 0;
    while (scl_pull_low) begin n++; @(negedge clk); end
    check("R6 low after early pull", n, 4);

    @(negedge clk); enable = 0; tick = 0; cfg_high = 2; cfg_low = 2;
    repeat (6) @(negedge clk);
    enable = 1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (scl_pull_low) n++;
      @(negedge clk);
    end
    check("R7 no pull without tick", n, 0);
    tick = 1;
    n = 0;
    while (!scl_pull_low && n < 50) begin n++; @(negedge clk); end
    check("R7 resumes with tick", int'(scl_pull_low), 1);

    setup(20, 2);
    while (!scl_pull_low) @(negedge clk);
    while (scl_pull_low) @(negedge clk);
    n = 0;
    while (!scl_pull_low) begin
      n++;
      glitch = (n == 10);
      @(negedge clk);
    end
    glitch = 0;
    check("R8 glitch filtered", n, 26);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule